// File: doc/BRIEF.md
# Four-stage in-order pipeline controller

This block is the control unit of a strictly in-order pipeline with four steps: Fetch, Decode, Execute and Write. It does no arithmetic and holds no data. It drives a fetch address to an instruction source and receives, in the same cycle, a small token. The token describes the instruction: a valid flag, two source register indices, a destination register index, a store flag, a taken-branch flag and a branch target. The controller moves tokens through three stage registers. Fetch is the cycle in which the token is read at the current fetch address. A scoreboard holds one pending bit per register.

There is no operand forwarding. An instruction that needs a register still being written by an older instruction waits at the Fetch/Decode boundary. It repeats its fetch each cycle and enters Decode in the cycle after its producer has been in Write. Fetch and stores share one memory port: a store in Write takes the port, and fetch waits that cycle. A branch that reaches Decode discards the instruction being fetched and sends fetch to its target. An interrupt that is pending when an instruction leaves Write empties the younger stages and sends fetch to a fixed service address. Each taken redirect records a return address. A retire strobe with the instruction's tag (its fetch address) and a free-running cycle counter let a test measure total execution time.

Top module: `pipe4_ctrl`

## Requirements
- R1: While reset is asserted and on its release: fetch address 0, retire strobe low, cycle counter 0, return address 0, fetch request high.
- R2: Each stage takes exactly one cycle. An instruction fetched in the cycle where the counter reads n, with no hazard, retires in the cycle where it reads n+3. Independent instructions retire in consecutive cycles.
- R3: A valid token is held in Fetch while one of its source indices names a register with a pending write from an older instruction. While held, the stall-decode output is high and the fetch address is unchanged. The pending write no longer blocks once the producer is in Write, so the token enters Decode in the next cycle. A dependent back-to-back pair therefore retires 3 cycles apart, with two bubbles.
- R4: Consider this six-instruction program starting at address 0: load R1 (reads R2); add R3 from R1, R4; load R5 (reads R3); multiply into R6 from R5, R7; R1 from R1; R2 from R2. It retires at counter values 3, 6, 9, 12, 13 and 14, which is 15 cycles in total.
- R5: Register index 0 never creates a dependence, whether it appears as a source or as a destination.
- R6: A token whose destination register has a pending write from an older instruction is also held in Fetch, so that a register never has two writers in flight.
- R7: While a valid store is in Write, the fetch request is low and the stall-fetch output is high. No token is taken in that cycle, and the same address is fetched in the next cycle.
- R8: While a branch token is in Decode, the token fetched in that cycle is discarded and never retires. The return address becomes the branch tag plus 1, and the next cycle fetches the branch target. The branch itself retires.
- R9: When an instruction retires while the interrupt input is high, the instructions in Decode, in Execute and at the fetch address are discarded and all pending bits are cleared. The return address becomes the tag of the oldest discarded instruction, searched in the order Execute, then Decode, then the fetch address. The next cycle fetches the service address (default 64).
- R10: The retire strobe is high for exactly one cycle per instruction that is not discarded, and the retire tag equals the instruction's fetch address.
- R11: The cycle counter increases by one every clock cycle after reset.
- R12: When the source returns a token with the valid flag low, a bubble enters Decode and the fetch address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Token at the fetch address is an instruction |
| i_rs1 | input | 3 | First source register index (0 = none) |
| i_rs2 | input | 3 | Second source register index (0 = none) |
| i_rd | input | 3 | Destination register index (0 = none) |
| i_store | input | 1 | Token is a memory store |
| i_branch | input | 1 | Token is a taken branch |
| i_target | input | 8 | Branch target address |
| irq | input | 1 | Pending interrupt |
| imem_addr | output | 8 | Current fetch address |
| imem_req | output | 1 | Fetch uses the memory port this cycle |
| stall_fetch | output | 1 | Fetch blocked by a store in Write |
| stall_dec | output | 1 | Fetched token held on a register dependence |
| retire_valid | output | 1 | An instruction is in Write this cycle |
| retire_tag | output | 8 | Fetch address of the retiring instruction |
| link_addr | output | 8 | Last saved return address |
| cycle_count | output | 16 | Free-running cycle counter |

## Verification
The hardest case to reach is an interrupt taken exactly when Execute and Decode both hold instructions that have already set pending bits. If the scoreboard kept those stale bits, the service routine would stall forever. The bench counts cycles from reset release and raises the interrupt only in the cycle where the first instruction is in Write. The service instruction reads the registers of the discarded instructions, so it retires only if the flush also cleared the scoreboard. The branch and store cases use similar cycle-exact placement, aligning a redirect or a port conflict with a particular fetch.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int NREG = 8;
  localparam int RW   = $clog2(NREG);
  localparam int PC_W = 8;

  typedef logic [RW-1:0]   ridx_t;
  typedef logic [PC_W-1:0] pc_t;
  typedef logic [NREG-1:0] rmask_t;

  typedef struct packed {
    logic  valid;
    ridx_t rs1;
    ridx_t rs2;
    ridx_t rd;
    logic  store;
    logic  branch;
    pc_t   target;
    pc_t   tag;
  } tok_t;

  localparam tok_t BUBBLE = '0;

  // one-hot register mask; index 0 never tracked
  function automatic rmask_t reg_bit(ridx_t i);
    rmask_t m;
    m    = '0;
    m[i] = 1'b1;
    m[0] = 1'b0;
    return m;
  endfunction

  function automatic logic writes_reg(tok_t t);
    return t.valid && (t.rd != '0);
  endfunction

  // registers a token must find free before entering Decode
  function automatic rmask_t touch_mask(tok_t t);
    return reg_bit(t.rs1) | reg_bit(t.rs2) | reg_bit(t.rd);
  endfunction

  function automatic logic conflicts(tok_t younger, tok_t older);
    return writes_reg(older) && younger.valid &&
           ((touch_mask(younger) & reg_bit(older.rd)) != '0);
  endfunction

  function automatic pc_t pc_step(pc_t p);
    return p + pc_t'(1);
  endfunction
endpackage

// File: rtl/pipe4_scoreboard.sv
module pipe4_scoreboard
  import pipe4_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   set_en,
  input  ridx_t  set_idx,
  input  logic   clr_en,
  input  ridx_t  clr_idx,
  input  logic   flush,
  input  rmask_t need,
  output logic   hazard,
  output rmask_t pending
);
  rmask_t clr_m;
  rmask_t set_m;
  rmask_t live;

  always_comb begin
    clr_m  = clr_en ? reg_bit(clr_idx) : '0;
    set_m  = set_en ? reg_bit(set_idx) : '0;
    live   = pending & ~clr_m;       // a write leaving Write no longer blocks
    hazard = (live & need) != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pending <= '0;
    else if (flush) pending <= '0;
    else            pending <= live | set_m;
  end

  AST_CLR_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_idx != '0) |-> pending[clr_idx]) else $error("clear of idle register"); // R3
endmodule

// File: rtl/pipe4_fetch.sv
module pipe4_fetch
  import pipe4_pkg::*;
#(
  parameter pc_t ISR_ADDR = pc_t'(64)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  i_valid,
  input  ridx_t i_rs1,
  input  ridx_t i_rs2,
  input  ridx_t i_rd,
  input  logic  i_store,
  input  logic  i_branch,
  input  pc_t   i_target,
  input  logic  port_busy,
  input  logic  hazard,
  input  logic  br_take,
  input  pc_t   br_target,
  input  pc_t   br_link,
  input  logic  irq_take,
  input  pc_t   irq_link,
  output pc_t   pc,
  output logic  req,
  output tok_t  f_tok,
  output logic  f_go,
  output logic  stall_dec,
  output pc_t   link
);
  pc_t pc_n;
  logic redirect;

  always_comb begin
    req          = !port_busy;
    f_tok.valid  = req && i_valid;
    f_tok.rs1    = i_rs1;
    f_tok.rs2    = i_rs2;
    f_tok.rd     = i_rd;
    f_tok.store  = i_store;
    f_tok.branch = i_branch;
    f_tok.target = i_target;
    f_tok.tag    = pc;
    redirect     = br_take || irq_take;
    f_go         = f_tok.valid && !hazard && !redirect;
    stall_dec    = f_tok.valid && hazard;
    if (irq_take)     pc_n = ISR_ADDR;
    else if (br_take) pc_n = br_target;
    else if (f_go)    pc_n = pc_step(pc);
    else              pc_n = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      link <= '0;
    end else begin
      pc <= pc_n;
      if (irq_take)     link <= irq_link;
      else if (br_take) link <= br_link;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_dec && !redirect) |=> $stable(pc)) else $error("fetch moved during stall"); // R3
  AST_HOLD_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !i_valid && !redirect) |=> $stable(pc)) else $error("fetch moved on empty token"); // R12
endmodule

// File: rtl/pipe4_stages.sv
module pipe4_stages
  import pipe4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic f_go,
  input  tok_t f_tok,
  input  logic kill,
  output tok_t d_q,
  output tok_t e_q,
  output tok_t w_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= BUBBLE;
      e_q <= BUBBLE;
      w_q <= BUBBLE;
    end else begin
      d_q <= f_go ? f_tok : BUBBLE;
      e_q <= kill ? BUBBLE : d_q;
      w_q <= kill ? BUBBLE : e_q;
    end
  end

  AST_NO_OLDER_WRITER_E: assert property (@(posedge clk) disable iff (!rst_n)
    !conflicts(d_q, e_q)) else $error("Decode overlaps Execute writer"); // R6
  AST_NO_OLDER_WRITER_W: assert property (@(posedge clk) disable iff (!rst_n)
    !conflicts(d_q, w_q)) else $error("Decode overlaps Write writer"); // R3
endmodule

// File: rtl/pipe4_ctrl.sv
module pipe4_ctrl
  import pipe4_pkg::*;
#(
  parameter pc_t ISR_ADDR = pc_t'(64),
  parameter int  CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_valid,
  input  logic [RW-1:0]    i_rs1,
  input  logic [RW-1:0]    i_rs2,
  input  logic [RW-1:0]    i_rd,
  input  logic             i_store,
  input  logic             i_branch,
  input  logic [PC_W-1:0]  i_target,
  input  logic             irq,
  output logic [PC_W-1:0]  imem_addr,
  output logic             imem_req,
  output logic             stall_fetch,
  output logic             stall_dec,
  output logic             retire_valid,
  output logic [PC_W-1:0]  retire_tag,
  output logic [PC_W-1:0]  link_addr,
  output logic [CNT_W-1:0] cycle_count
);
  tok_t   f_tok, d_q, e_q, w_q;
  rmask_t pending;
  logic   hazard, f_go, port_busy, br_take, irq_take;
  pc_t    br_link, irq_link;

  // named events shared by the sub-blocks and the assertions
  always_comb begin
    port_busy = w_q.valid && w_q.store;
    irq_take  = w_q.valid && irq;
    br_take   = d_q.valid && d_q.branch && !irq_take;
    br_link   = pc_step(d_q.tag);
    if (e_q.valid)      irq_link = e_q.tag;
    else if (d_q.valid) irq_link = d_q.tag;
    else                irq_link = imem_addr;
  end

  pipe4_fetch #(.ISR_ADDR(ISR_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .i_valid(i_valid), .i_rs1(i_rs1), .i_rs2(i_rs2), .i_rd(i_rd),
    .i_store(i_store), .i_branch(i_branch), .i_target(i_target),
    .port_busy(port_busy), .hazard(hazard),
    .br_take(br_take), .br_target(d_q.target), .br_link(br_link),
    .irq_take(irq_take), .irq_link(irq_link),
    .pc(imem_addr), .req(imem_req), .f_tok(f_tok), .f_go(f_go),
    .stall_dec(stall_dec), .link(link_addr)
  );

  pipe4_scoreboard u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_en(f_go && f_tok.rd != '0), .set_idx(f_tok.rd),
    .clr_en(writes_reg(w_q)), .clr_idx(w_q.rd),
    .flush(irq_take), .need(touch_mask(f_tok)),
    .hazard(hazard), .pending(pending)
  );

  pipe4_stages u_stg (
    .clk(clk), .rst_n(rst_n), .f_go(f_go), .f_tok(f_tok), .kill(irq_take),
    .d_q(d_q), .e_q(e_q), .w_q(w_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cycle_count <= '0;
    else        cycle_count <= cycle_count + CNT_W'(1);
  end

  assign stall_fetch  = port_busy;
  assign retire_valid = w_q.valid;
  assign retire_tag   = w_q.tag;

  AST_PENDING_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pending) == (int'(writes_reg(d_q)) + int'(writes_reg(e_q)) + int'(writes_reg(w_q))))
    else $error("scoreboard out of step with stages"); // R3
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_dec |=> !d_q.valid) else $error("stalled token reached Decode"); // R3
  AST_STORE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |=> !d_q.valid) else $error("fetch shared port with store"); // R7
  AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> (!d_q.valid && e_q.valid && e_q.branch && imem_addr == $past(d_q.target)))
    else $error("branch redirect wrong"); // R8
  AST_IRQ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (!d_q.valid && !e_q.valid && !w_q.valid && pending == '0 && imem_addr == ISR_ADDR))
    else $error("interrupt flush wrong"); // R9
endmodule

// File: tb/pipe4_ctrl_test.sv
module pipe4_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq = 1'b0;
  logic       i_valid, i_store, i_branch;
  logic [2:0] i_rs1, i_rs2, i_rd;
  logic [7:0] i_target;
  logic [7:0] imem_addr, retire_tag, link_addr;
  logic       imem_req, stall_fetch, stall_dec, retire_valid;
  logic [15:0] cycle_count;

  logic       m_v  [0:255];
  logic [2:0] m_s1 [0:255];
  logic [2:0] m_s2 [0:255];
  logic [2:0] m_d  [0:255];
  logic       m_st [0:255];
  logic       m_br [0:255];
  logic [7:0] m_tg [0:255];

  int ret_at [0:255];
  int ret_total, sd_n, sf_n, rq_lo;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  assign i_valid  = m_v[imem_addr];
  assign i_rs1    = m_s1[imem_addr];
  assign i_rs2    = m_s2[imem_addr];
  assign i_rd     = m_d[imem_addr];
  assign i_store  = m_st[imem_addr];
  assign i_branch = m_br[imem_addr];
  assign i_target = m_tg[imem_addr];

  pipe4_ctrl uut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_rs1(i_rs1), .i_rs2(i_rs2),
    .i_rd(i_rd), .i_store(i_store), .i_branch(i_branch), .i_target(i_target),
    .irq(irq), .imem_addr(imem_addr), .imem_req(imem_req),
    .stall_fetch(stall_fetch), .stall_dec(stall_dec), .retire_valid(retire_valid),
    .retire_tag(retire_tag), .link_addr(link_addr), .cycle_count(cycle_count)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (retire_valid) begin
        ret_at[retire_tag] = int'(cycle_count);
        ret_total++;
      end
      if (stall_dec)   sd_n++;
      if (stall_fetch) sf_n++;
      if (!imem_req)   rq_lo++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_test();
    rst_n = 1'b0;
    irq   = 1'b0;
    for (int a = 0; a < 256; a++) begin
      m_v[a] = 1'b0; m_s1[a] = '0; m_s2[a] = '0; m_d[a] = '0;
      m_st[a] = 1'b0; m_br[a] = 1'b0; m_tg[a] = '0;
      ret_at[a] = -1;
    end
    ret_total = 0; sd_n = 0; sf_n = 0; rq_lo = 0;
    @(posedge clk);
  endtask

  task automatic put(input int a, input int s1, input int s2, input int d,
                     input bit st, input bit br, input int tg);
    m_v[a] = 1'b1; m_s1[a] = 3'(s1); m_s2[a] = 3'(s2); m_d[a] = 3'(d);
    m_st[a] = st; m_br[a] = br; m_tg[a] = 8'(tg);
  endtask

  task automatic go();
    @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    begin_test();
    #1;
    chk("R1 fetch address", int'(imem_addr), 0);
    chk("R1 retire strobe", int'(retire_valid), 0);
    chk("R1 cycle counter", int'(cycle_count), 0);
    chk("R1 return address", int'(link_addr), 0);
    chk("R1 fetch request", int'(imem_req), 1);
    go();
    run(5);
    chk("R11 counter after 5 edges", int'(cycle_count), 5);
    run(3);
    chk("R11 counter after 8 edges", int'(cycle_count), 8);
    chk("R12 empty fetch holds address", int'(imem_addr), 0);
  endtask

  task automatic t_sequence();
    begin_test();
    put(0, 2, 0, 1, 0, 0, 0);
    put(1, 1, 4, 3, 0, 0, 0);
    put(2, 3, 0, 5, 0, 0, 0);
    put(3, 5, 7, 6, 0, 0, 0);
    put(4, 1, 0, 1, 0, 0, 0);
    put(5, 2, 0, 2, 0, 0, 0);
    go();
    run(20);
    chk("R2 first load retire", ret_at[0], 3);
    chk("R3 add after load", ret_at[1], 6);
    chk("R3 load after add", ret_at[2], 9);
    chk("R3 multiply after load", ret_at[3], 12);
    chk("R2 independent update", ret_at[4], 13);
    chk("R4 last retire at 14 (15 cycles)", ret_at[5], 14);
    chk("R3 decode stall cycles", sd_n, 6);
    chk("R10 retire count", ret_total, 6);
  endtask

  task automatic t_zero();
    begin_test();
    put(0, 1, 2, 0, 0, 0, 0);
    put(1, 0, 0, 3, 0, 0, 0);
    put(2, 0, 0, 0, 0, 0, 0);
    put(3, 0, 0, 0, 0, 0, 0);
    go();
    run(12);
    chk("R5 writer of index 0", ret_at[0], 3);
    chk("R5 reader of index 0", ret_at[1], 4);
    chk("R5 second index-0 write", ret_at[2], 5);
    chk("R5 third index-0 write", ret_at[3], 6);
    chk("R5 no decode stall", sd_n, 0);
  endtask

  task automatic t_waw();
    begin_test();
    put(0, 0, 0, 2, 0, 0, 0);
    put(1, 0, 0, 2, 0, 0, 0);
    go();
    run(12);
    chk("R6 first writer", ret_at[0], 3);
    chk("R6 second writer waits", ret_at[1], 6);
    chk("R6 stall cycles", sd_n, 2);
  endtask

  task automatic t_indep();
    begin_test();
    put(0, 6, 7, 1, 0, 0, 0);
    put(1, 6, 0, 2, 0, 0, 0);
    put(2, 7, 0, 3, 0, 0, 0);
    put(3, 6, 7, 4, 0, 0, 0);
    go();
    run(12);
    chk("R2 stream slot 0", ret_at[0], 3);
    chk("R2 stream slot 1", ret_at[1], 4);
    chk("R2 stream slot 2", ret_at[2], 5);
    chk("R2 stream slot 3", ret_at[3], 6);
  endtask

  task automatic t_store();
    begin_test();
    put(0, 2, 1, 0, 1, 0, 0);
    put(1, 0, 0, 3, 0, 0, 0);
    put(2, 0, 0, 4, 0, 0, 0);
    put(3, 0, 0, 5, 0, 0, 0);
    go();
    run(15);
    chk("R7 store retire", ret_at[0], 3);
    chk("R7 fetch before store write", ret_at[2], 5);
    chk("R7 delayed fetch retire", ret_at[3], 7);
    chk("R7 stall-fetch cycles", sf_n, 1);
    chk("R7 request-low cycles", rq_lo, 1);
    chk("R12 address held after program", int'(imem_addr), 4);
  endtask

  task automatic t_branch();
    begin_test();
    put(0, 0, 0, 1, 0, 0, 0);
    put(1, 0, 0, 0, 0, 1, 20);
    put(2, 0, 0, 2, 0, 0, 0);
    put(20, 0, 0, 5, 0, 0, 0);
    go();
    run(14);
    chk("R8 older instruction", ret_at[0], 3);
    chk("R8 branch retires", ret_at[1], 4);
    chk("R8 fetched-behind discarded", ret_at[2], -1);
    chk("R8 target retires", ret_at[20], 6);
    chk("R8 return address", int'(link_addr), 2);
    chk("R10 retire count", ret_total, 3);
  endtask

  task automatic t_irq();
    begin_test();
    for (int a = 0; a < 6; a++) put(a, 0, 0, a + 1, 0, 0, 0);
    put(64, 2, 3, 7, 0, 0, 0);
    go();
    while (int'(cycle_count) != 3) run(1);
    irq = 1'b1;
    run(1);
    irq = 1'b0;
    run(10);
    chk("R9 retiring instruction", ret_at[0], 3);
    chk("R9 Execute discarded", ret_at[1], -1);
    chk("R9 Decode discarded", ret_at[2], -1);
    chk("R9 fetch discarded", ret_at[3], -1);
    chk("R9 service instruction (scoreboard cleared)", ret_at[64], 7);
    chk("R9 return address", int'(link_addr), 1);
    chk("R10 retire count", ret_total, 2);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_zero();
    t_waw();
    t_indep();
    t_store();
    t_branch();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule